// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller

This block manages a bank of general-purpose pins behind a word-addressed register interface. Each pin belongs either to the controller, where software drives it as an input or an output, or to one of two internal peripheral functions whose output and enable signals are routed straight to the pad. Per-pin drive options are pull-up, open-drain and an input glitch filter. Pin changes are recorded as pending flags that can raise one interrupt line.

Every per-pin attribute has two write-only registers. Writing a one to a bit of the "set" register turns the attribute on for that pin. Writing a one to a bit of the "clear" register turns it off. Zero bits leave the state alone. Software can therefore change a single pin without a read-modify-write sequence.

Pad inputs are synchronized, optionally filtered, and compared with their previous value. A change in either direction sets a pending flag. Reading the pending register returns the flags and clears them in the same access.

Top module: `pio_mux_ctrl`

## Requirements
- R1: After reset, all pins belong to the controller as inputs with outputs low. Pull-ups are on. Open-drain, filter and interrupt masks are off. No flags are pending, `pad_oe` is zero and `irq` is low.
- R2: Writes use these word addresses. Ownership: set 0, clear 1, read 2. Peripheral select: A 3, B 4, read 5 (bit 1 = B). Output enable: 6, 7, 8. Output data: 9, 10, 11. Pull-up: 12, 13, 14. Open-drain: 15, 16, 17. Filter: 18, 19, 20. Interrupt mask: 21, 22, 23. Pad level: read 24. Pending flags: read 25. A one at a set address turns a pin's bit on, and a one at a clear address turns it off. Zero bits leave the bit unchanged.
- R3: A pin with its ownership bit at 0 takes its pad output and enable from peripheral A when its select bit is 0, and from peripheral B when its select bit is 1.
- R4: A controller-owned pin with output enable on drives its output-data bit onto `pad_out` and asserts `pad_oe`.
- R5: A pin in open-drain mode never drives high. With data 1 it releases the pad (`pad_oe` low, `pad_out` low). With data 0 it drives low.
- R6: The pad-level register returns every pad's level after a two-flop synchronizer, whatever the pin's ownership or direction.
- R7: Both rising and falling pin changes set the pin's pending flag.
- R8: Reading address 25 returns the pending flags and clears them.
- R9: `irq` is high whenever a pending flag is set for a pin whose mask bit is set. The mask reads back at address 23.
- R10: With the filter on for a pin, a pulse that lasts one clock after synchronization is ignored. A pulse of two clocks or more is passed on with two extra clocks of delay.
- R11: A change detected in the same cycle as a read of the pending flags stays pending after the read.
- R12: `pad_pu` follows the pull-up register bit for each pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NPIN | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | NPIN | Read data, valid while rd_en is high |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad output enables |
| pad_pu | output | NPIN | Pad pull-up enables |
| per_a_out | input | NPIN | Peripheral A output data |
| per_a_oe | input | NPIN | Peripheral A output enable |
| per_b_out | input | NPIN | Peripheral B output data |
| per_b_oe | input | NPIN | Peripheral B output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults, a full bank of 32 pins and a 5-bit address. The top pin, bit 31, therefore takes part in the level and change tests, alongside the low pins that are handed to the peripherals. One pulse is sized to fall inside the filter window and one just outside it. A pin change is placed in exactly the cycle of a pending-flag read, to show that it survives the read.

// File: rtl/pio_mux_ctrl.sv
module pio_mux_ctrl #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [NPIN-1:0] wr_data,
  input  logic            rd_en,
  output logic [NPIN-1:0] rd_data,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pu,
  input  logic [NPIN-1:0] per_a_out,
  input  logic [NPIN-1:0] per_a_oe,
  input  logic [NPIN-1:0] per_b_out,
  input  logic [NPIN-1:0] per_b_oe,
  output logic            irq
);
  localparam logic [AW-1:0] OWN_S = AW'(0),  OWN_C = AW'(1),  OWN_R = AW'(2);
  localparam logic [AW-1:0] SEL_A = AW'(3),  SEL_B = AW'(4),  SEL_R = AW'(5);
  localparam logic [AW-1:0] OE_S  = AW'(6),  OE_C  = AW'(7),  OE_R  = AW'(8);
  localparam logic [AW-1:0] DO_S  = AW'(9),  DO_C  = AW'(10), DO_R  = AW'(11);
  localparam logic [AW-1:0] PU_S  = AW'(12), PU_C  = AW'(13), PU_R  = AW'(14);
  localparam logic [AW-1:0] OD_S  = AW'(15), OD_C  = AW'(16), OD_R  = AW'(17);
  localparam logic [AW-1:0] FL_S  = AW'(18), FL_C  = AW'(19), FL_R  = AW'(20);
  localparam logic [AW-1:0] IM_S  = AW'(21), IM_C  = AW'(22), IM_R  = AW'(23);
  localparam logic [AW-1:0] LVL_R = AW'(24), PEND_R = AW'(25);

  logic [NPIN-1:0] own_q, sel_q, oe_q, do_q, pu_q, od_q, flt_q, im_q;
  logic [NPIN-1:0] isr_q, s1_q, s2_q, s3_q, filt_q, prev_q;
  logic [NPIN-1:0] lvl, chg, src_out, src_oe;
  logic            rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= '1;
      sel_q <= '0;
      oe_q  <= '0;
      do_q  <= '0;
      pu_q  <= '1;
      od_q  <= '0;
      flt_q <= '0;
      im_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OWN_S: own_q <= own_q | wr_data;
        OWN_C: own_q <= own_q & ~wr_data;
        SEL_A: sel_q <= sel_q & ~wr_data;
        SEL_B: sel_q <= sel_q | wr_data;
        OE_S:  oe_q  <= oe_q | wr_data;
        OE_C:  oe_q  <= oe_q & ~wr_data;
        DO_S:  do_q  <= do_q | wr_data;
        DO_C:  do_q  <= do_q & ~wr_data;
        PU_S:  pu_q  <= pu_q | wr_data;
        PU_C:  pu_q  <= pu_q & ~wr_data;
        OD_S:  od_q  <= od_q | wr_data;
        OD_C:  od_q  <= od_q & ~wr_data;
        FL_S:  flt_q <= flt_q | wr_data;
        FL_C:  flt_q <= flt_q & ~wr_data;
        IM_S:  im_q  <= im_q | wr_data;
        IM_C:  im_q  <= im_q & ~wr_data;
        default: ;
      endcase
    end
  end

  assign lvl     = (flt_q & filt_q) | (~flt_q & s2_q);
  assign chg     = lvl ^ prev_q;
  assign rd_pend = rd_en && (addr == PEND_R);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      filt_q <= '0;
      prev_q <= '0;
      isr_q  <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      filt_q <= (s2_q & ~(s2_q ^ s3_q)) | (filt_q & (s2_q ^ s3_q));
      prev_q <= lvl;
      isr_q  <= (rd_pend ? '0 : isr_q) | chg;
    end
  end

  assign src_out = (own_q & do_q) | (~own_q & ~sel_q & per_a_out) | (~own_q & sel_q & per_b_out);
  assign src_oe  = (own_q & oe_q) | (~own_q & ~sel_q & per_a_oe)  | (~own_q & sel_q & per_b_oe);
  assign pad_oe  = src_oe & ~(od_q & src_out);
  assign pad_out = src_out & ~od_q;
  assign pad_pu  = pu_q;
  assign irq     = |(isr_q & im_q);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        OWN_R:  rd_data = own_q;
        SEL_R:  rd_data = sel_q;
        OE_R:   rd_data = oe_q;
        DO_R:   rd_data = do_q;
        PU_R:   rd_data = pu_q;
        OD_R:   rd_data = od_q;
        FL_R:   rd_data = flt_q;
        IM_R:   rd_data = im_q;
        LVL_R:  rd_data = s2_q;
        PEND_R: rd_data = isr_q;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_mux_ctrl_chk.sv
module pio_mux_ctrl_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr,
  input logic            wr_en,
  input logic [NPIN-1:0] wr_data,
  input logic            rd_en,
  input logic [NPIN-1:0] oe_q,
  input logic [NPIN-1:0] od_q,
  input logic [NPIN-1:0] isr_q,
  input logic [NPIN-1:0] chg,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_out
);
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_q) == '0); // R5
  AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(6)) |=> ((oe_q & $past(wr_data)) == $past(wr_data))); // R2
  AST_CLR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(7)) |=> ((oe_q & $past(wr_data)) == '0)); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(oe_q)); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(25) && chg == '0) |=> (isr_q == '0)); // R8
  AST_CHANGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((isr_q & $past(chg)) == $past(chg))); // R11
endmodule

bind pio_mux_ctrl pio_mux_ctrl_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .oe_q(oe_q), .od_q(od_q), .isr_q(isr_q), .chg(chg),
  .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/pio_mux_ctrl_tb.sv
module pio_mux_ctrl_tb;
  localparam int NPIN = 32;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [NPIN-1:0] wr_data = '0, pad_in = '0;
  logic [NPIN-1:0] per_a_out = '0, per_a_oe = '0, per_b_out = '0, per_b_oe = '0;
  logic [NPIN-1:0] rd_data, pad_out, pad_oe, pad_pu;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pio_mux_ctrl #(.NPIN(NPIN), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .per_a_out(per_a_out), .per_a_oe(per_a_oe),
    .per_b_out(per_b_out), .per_b_oe(per_b_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = AW'(a); #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R12 pad_pu", pad_pu, 32'hFFFF_FFFF);
    rd(2, v);  chk("R1 ownership", v, 32'hFFFF_FFFF);
    rd(14, v); chk("R1 pull-up", v, 32'hFFFF_FFFF);
    rd(8, v);  chk("R1 output enable", v, 0);
    rd(23, v); chk("R1 mask", v, 0);
    rd(25, v); chk("R1 pending", v, 0);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(6, 32'h0000_00F0); wr(7, 32'h0000_0030);
    rd(8, v); chk("R2 set/clear", v, 32'h0000_00C0);
    wr(6, 0); wr(7, 0);
    rd(8, v); chk("R2 zero bits unchanged", v, 32'h0000_00C0);
  endtask

  task automatic t_data;
    wr(9, 32'h80);
    chk("R4 pad_out set", pad_out, 32'h80);
    chk("R4 pad_oe", pad_oe, 32'hC0);
    wr(10, 32'h80);
    chk("R4 pad_out clear", pad_out, 0);
  endtask

  task automatic t_od;
    wr(15, 32'hC0); wr(9, 32'h40);
    chk("R5 open-drain oe", pad_oe & 32'hC0, 32'h80);
    chk("R5 open-drain out", pad_out & 32'hC0, 0);
    wr(16, 32'hC0);
    chk("R5 push-pull again", pad_oe & 32'hC0, 32'hC0);
    wr(7, 32'hFFFF_FFFF); wr(10, 32'hFFFF_FFFF);
  endtask

  task automatic t_mux;
    logic [31:0] v;
    per_a_out = 32'h1; per_a_oe = 32'h3; per_b_out = 32'h2; per_b_oe = 32'h2;
    wr(1, 32'h3); wr(4, 32'h2);
    chk("R3 A and B out", pad_out & 3, 3);
    chk("R3 A and B oe", pad_oe & 3, 3);
    per_b_oe = 0; #1;
    chk("R3 B enable routed", pad_oe & 3, 1);
    rd(5, v); chk("R3 select readback", v, 2);
    wr(3, 32'h2);
    chk("R3 back to A oe", pad_oe & 3, 3);
    chk("R3 back to A out", pad_out & 3, 1);
    wr(0, 32'h3);
    chk("R3 controller owns again", pad_oe & 3, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); pad_in = 32'hA5A5_0000;
    repeat (4) @(negedge clk);
    rd(24, v); chk("R6 level", v, 32'hA5A5_0000);
    rd(25, v); chk("R7 rising flags", v, 32'hA5A5_0000);
    rd(25, v); chk("R8 cleared by read", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    @(negedge clk); pad_in = 32'hA5A4_0000;
    repeat (4) @(negedge clk);
    chk("R9 irq masked", {31'd0, irq}, 0);
    wr(21, 32'h0001_0000);
    chk("R9 irq raised", {31'd0, irq}, 1);
    rd(23, v); chk("R9 mask readback", v, 32'h0001_0000);
    rd(25, v); chk("R7 falling flag", v, 32'h0001_0000);
    chk("R8 irq drops after read", {31'd0, irq}, 0);
    @(negedge clk); pad_in = 32'hA5A4_0001;
    repeat (4) @(negedge clk);
    chk("R9 unmasked pin no irq", {31'd0, irq}, 0);
    rd(25, v); chk("R7 flag without mask", v, 1);
  endtask

  task automatic t_filter;
    logic [31:0] v;
    wr(18, 32'h100);
    @(negedge clk); pad_in[8] = 1;
    @(negedge clk); pad_in[8] = 0;
    repeat (6) @(negedge clk);
    rd(25, v); chk("R10 short pulse rejected", v, 0);
    @(negedge clk); pad_in[8] = 1;
    repeat (3) @(negedge clk); pad_in[8] = 0;
    repeat (6) @(negedge clk);
    rd(25, v); chk("R10 long pulse passed", v, 32'h100);
    @(negedge clk); pad_in[9] = 1;
    @(negedge clk); pad_in[9] = 0;
    repeat (6) @(negedge clk);
    rd(25, v); chk("R10 unfiltered pin", v, 32'h200);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    @(negedge clk); pad_in[12] = 1;
    @(posedge clk); @(posedge clk);
    rd(25, v); chk("R11 read before flag", v, 0);
    rd(25, v); chk("R11 flag kept", v, 32'h1000);
  endtask

  task automatic t_pullup;
    wr(13, 32'hF);
    chk("R12 pull-up clear", pad_pu, 32'hFFFF_FFF0);
    wr(12, 32'h1);
    chk("R12 pull-up set", pad_pu, 32'hFFFF_FFF1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_setclr();
    t_data();
    t_od();
    t_mux();
    t_level();
    t_irq();
    t_filter();
    t_same_cycle();
    t_pullup();
    finish_run();
  end
endmodule